// File: doc/BRIEF.md
# Chained Swap-Subtract GCD Unit

This block finds the greatest common divisor of two unsigned operands. It works by repeated subtraction. The working pair is (x, y). A swap step exchanges the two when x is below y. A subtract step replaces x with x - y when x is at least y. Both steps apply only while y is non-zero.

Within one clock cycle, a swap stage is followed by a subtract stage. The subtract stage sees the pair that the swap stage just produced. A parameter chains one or two such swap-subtract pairs per cycle. This trades a longer combinational path for fewer cycles per result.

A caller presents both operands with a one-cycle `start` pulse while the unit is idle. It then waits for `done`. Once `done` is high, `result` holds the divisor and `cycles` holds the number of iteration cycles the run took. These values stay until the next accepted start.

Top module: `chained_gcd`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `result` and `cycles` are 0.
- R2: A `start` sampled high while `busy` is 0 loads `a_in` into x and `b_in` into y. From the next cycle, `busy` is 1 and `done` is 0.
- R3: A swap stage exchanges x and y when x < y and y != 0. Otherwise it passes the pair unchanged.
- R4: A subtract stage replaces x with x - y when x >= y and y != 0. Its condition is evaluated on the outputs of the swap stage before it, so one pair can both swap and subtract.
- R5: When only one of the two steps of a pair is enabled, only that step changes the pair. When neither is enabled, the pair passes through unchanged.
- R6: With `CHAIN_DEPTH` = 2, each iteration cycle applies swap, subtract, swap, subtract in sequence, each stage fed by the previous one. With `CHAIN_DEPTH` = 1, each cycle applies one swap and then one subtract.
- R7: When y is 0 in a busy cycle, the unit sets `done`, outputs x on `result` and clears `busy`. `done`, `result` and `cycles` then hold until the next accepted start.
- R8: `start` while `busy` is 1 is ignored. The running computation's result and cycle count are unaffected.
- R9: If both operands are zero, the result is 0. If `b_in` is 0, the result is `a_in` with `cycles` 0. If only `a_in` is 0, the result is `b_in`.
- R10: `cycles` equals the number of busy cycles in which y was non-zero and the stage chain was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load operands and begin; honoured only while idle |
| a_in | input | WIDTH | First operand (initial x) |
| b_in | input | WIDTH | Second operand (initial y) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid, held until next start |
| result | output | WIDTH | Greatest common divisor |
| cycles | output | CNT_W | Iteration cycles used by the last run |

## Verification
Two instances, one per chain depth, receive identical operands. Their cycle counts are compared with a bench step model, which tells a correct swap-then-subtract ordering from one in which the subtract sees stale values. Directed cases cover zero operands, equal operands, coprime pairs with a long subtraction run, and x < y at load (swap first). Each of these tells apart a different guard condition. A start pulse in mid-run and a hold period after `done` show whether new operands leak in or outputs drift. Seeded random pairs then exercise the general mix of step patterns against a modulo-based divisor reference.

// File: rtl/gcd_pkg.sv
// Package: shared widths helper for the chained GCD unit.
// Assumes nothing beyond standard SystemVerilog.
package gcd_pkg;
    // Width of the iteration counter needed for operands of w bits.
    function automatic int cnt_width(input int w);
        return w + 1;
    endfunction
endpackage

// File: rtl/gcd_stage.sv
// Module: gcd_stage
// One swap stage followed by one subtract stage, purely combinational.
// The subtract guard is evaluated on the swapped pair.
// Assumes unsigned operands.
module gcd_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    output logic [WIDTH-1:0] x_out,
    output logic [WIDTH-1:0] y_out
);
    logic [WIDTH-1:0] xs, ys;

    // Swap stage: exchange when x < y and y is non-zero (R3).
    always_comb begin
        if ((x_in < y_in) && (y_in != '0)) begin
            xs = y_in;
            ys = x_in;
        end else begin
            xs = x_in;
            ys = y_in;
        end
    end

    // Subtract stage: uses the swapped pair (R4, R5).
    always_comb begin
        y_out = ys;
        if ((xs >= ys) && (ys != '0)) x_out = xs - ys;
        else                          x_out = xs;
    end
endmodule

// File: rtl/gcd_chain.sv
// Module: gcd_chain
// Cascades DEPTH swap-subtract stages within one cycle, each stage
// fed by the previous one. Assumes DEPTH is 1 or 2.
module gcd_chain #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    output logic [WIDTH-1:0] x_out,
    output logic [WIDTH-1:0] y_out
);
    logic [WIDTH-1:0] xv [DEPTH+1];
    logic [WIDTH-1:0] yv [DEPTH+1];

    assign xv[0] = x_in;
    assign yv[0] = y_in;

    // Stage cascade: one gcd_stage per chain level (R6).
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        gcd_stage #(.WIDTH(WIDTH)) u_stage (
            .x_in (xv[i]),
            .y_in (yv[i]),
            .x_out(xv[i+1]),
            .y_out(yv[i+1])
        );
    end

    assign x_out = xv[DEPTH];
    assign y_out = yv[DEPTH];
endmodule

// File: rtl/chained_gcd.sv
// Module: chained_gcd
// Top of the GCD unit. Accepts operands on start while idle, iterates
// the stage chain once per cycle until y is zero, then presents x as the
// result with the iteration cycle count. Assumes CHAIN_DEPTH is 1 or 2
// and that CNT_W covers the worst-case iteration count.
module chained_gcd #(
    parameter int WIDTH       = 16,
    parameter int CHAIN_DEPTH = 1,
    parameter int CNT_W       = gcd_pkg::cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic [CNT_W-1:0] cycles
);
    logic [WIDTH-1:0] x_q, y_q, x_nx, y_nx;
    logic [CNT_W-1:0] cnt_q;

    gcd_chain #(.WIDTH(WIDTH), .DEPTH(CHAIN_DEPTH)) u_chain (
        .x_in (x_q),
        .y_in (y_q),
        .x_out(x_nx),
        .y_out(y_nx)
    );

    // Control and datapath registers: load, iterate, finish (R1, R2, R7, R8, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
            cycles <= '0;
        end else if (start && !busy) begin
            x_q   <= a_in;
            y_q   <= b_in;
            cnt_q <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (y_q == '0) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                result <= x_q;
                cycles <= cnt_q;
            end else begin
                x_q   <= x_nx;
                y_q   <= y_nx;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    logic [WIDTH:0] sum_q;
    assign sum_q = {1'b0, x_q} + {1'b0, y_q};

    // R2: accepted start makes the unit busy with done cleared.
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R7: done and result hold while no new start arrives.
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result) && $stable(cycles)));

    // R7: busy and done never both high.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: an iteration never increases x + y.
    a_r4_sum_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && y_q != '0 && !$past(start && !busy)) |=> (sum_q <= $past(sum_q)));

    // R10: each applied iteration advances the counter by one.
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && y_q != '0) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/chained_gcd_bench.sv
module chained_gcd_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int CW = W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic busy1, done1, busy2, done2;
    logic [W-1:0] res1, res2;
    logic [CW-1:0] cyc1, cyc2;
    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chained_gcd #(.WIDTH(W), .CHAIN_DEPTH(1), .CNT_W(CW)) u_chained_gcd (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy1), .done(done1), .result(res1), .cycles(cyc1));

    chained_gcd #(.WIDTH(W), .CHAIN_DEPTH(2), .CNT_W(CW)) u_chained_gcd_deep (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy2), .done(done2), .result(res2), .cycles(cyc2));

    function automatic int ref_gcd(input int a, input int b);
        int t;
        while (b != 0) begin t = a % b; a = b; b = t; end
        return a;
    endfunction

    // Step model: per cycle, depth x (swap, then subtract).
    function automatic int ref_cycles(input int a, input int b, input int depth);
        int n = 0, t;
        while (b != 0) begin
            for (int d = 0; d < depth; d++) begin
                if (a < b && b != 0) begin t = a; a = b; b = t; end
                if (a >= b && b != 0) a = a - b;
            end
            n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_both_done();
        int guard = 0;
        while (!(done1 && done2) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        if (guard >= 2000) check("watchdog", 0, 1);
    endtask

    // Run one computation on both depths and check result and cycles.
    task automatic run(input int a, input int b, input string req);
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R2 busy"}, int'(busy1), 1);
        check({req, " R2 done cleared"}, int'(done1), 0);
        wait_both_done();
        check({req, " R7 result d1"}, int'(res1), ref_gcd(a, b));
        check({req, " R6 result d2"}, int'(res2), ref_gcd(a, b));
        check({req, " R10 cycles d1"}, int'(cyc1), ref_cycles(a, b, 1));
        check({req, " R6 cycles d2"}, int'(cyc2), ref_cycles(a, b, 2));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        check("watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int ra, rb, keep_res, keep_cyc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 busy", int'(busy1), 0);
        check("R1 done", int'(done1), 0);
        check("R1 result", int'(res1), 0);
        check("R1 cycles", int'(cyc1), 0);
        rst_n = 1'b1;

        run(0, 0, "R9 both zero");
        run(37, 0, "R9 b zero");
        check("R9 b zero cycles", int'(cyc1), 0);
        run(0, 45, "R9 a zero");
        run(21, 21, "R5 equal");
        run(9, 24, "R3 swap first");
        run(24, 9, "R4 subtract first");
        run(255, 1, "R10 long run");
        run(1, 255, "R3 R4 chain");
        run(128, 96, "R5 mixed");

        // R7: outputs hold after done with no start.
        keep_res = int'(res1); keep_cyc = int'(cyc1);
        repeat (6) @(negedge clk);
        check("R7 done held", int'(done1), 1);
        check("R7 result held", int'(res1), keep_res);
        check("R7 cycles held", int'(cyc1), keep_cyc);

        // R8: start in mid-run is ignored.
        @(negedge clk);
        a_in = 8'd60; b_in = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        a_in = 8'd7; b_in = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_both_done();
        check("R8 result d1", int'(res1), 1);
        check("R8 cycles d1", int'(cyc1), ref_cycles(60, 1, 1));
        check("R8 result d2", int'(res2), 1);
        check("R8 cycles d2", int'(cyc2), ref_cycles(60, 1, 2));

        // Random pairs, both depths (R4, R6, R10).
        for (int k = 0; k < 40; k++) begin
            ra = int'($urandom_range(0, 255));
            rb = int'($urandom_range(0, 255));
            run(ra, rb, "R4 R6 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule